// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the sampled D+ and D- lines of a low-speed USB link into a stream of received bytes. It runs from a system clock that is a fixed multiple of the bit rate, set by a parameter (ten clocks per bit by default). While idle it hunts for a J-to-K transition, the first edge of the sync field. It centres its bit sampler on that edge and treats two K samples in a row as the end of sync. After sync it decodes the NRZI line code from D-, drops the stuffed bit that follows every run of six ones, and packs the bits least-significant first into bytes.

Each completed byte comes out as a one-cycle strobe with the data and its write index, so a plain register file or RAM of `BUF_DEPTH` entries can sit directly behind it. An SE0 (both lines low) ends the packet, and a pulse then reports how many whole bytes were received. The check is skipped at bit 0 of each byte, so a short SE0 smear left by hub repeaters at a byte boundary does not end the packet. If a byte completes when the buffer is already full, the block raises an overflow pulse, drops that byte and abandons the packet.

Top module: `lowspeed_rx`

## Requirements
- R1: While reset is held and after it is released with the line idle, `byte_vld`, `pkt_end` and `ovf_err` stay low.
- R2: Line codes are {D+,D-}: J = 01, K = 10, SE0 = 00. The receiver starts a sync on a J-to-K edge and leaves sync only on two consecutive K bit samples. A sync of alternating K and J bits with no K-K pair produces no byte and no end pulse.
- R3: In sync, after `SYNC_TMO_BITS` bit samples with no new J-to-K edge, the receiver returns to hunting. A complete packet that follows is still received.
- R4: After sync, a bit reads 1 when D- holds the level of the previous bit period and 0 when it changes. The last sync K is the reference level for the first bit.
- R5: Bits are packed least-significant first. Each completed byte gives a one-cycle `byte_vld` with `byte_data` and a `byte_idx` that counts 0, 1, 2 and so on within the packet.
- R6: The bit that follows six consecutive decoded ones is discarded and is not packed into a byte.
- R7: SE0 sampled at bit positions 1 to 7 ends the packet. A one-cycle `pkt_end` then reports in `pkt_count` the number of whole bytes received, and any partial byte is dropped.
- R8: SE0 sampled at bit position 0 does not end the packet. It is decoded as a D- low level.
- R9: A byte that completes when `BUF_DEPTH` bytes are already held gives a one-cycle `ovf_err` and no `byte_vld`. Reception stops, and the SE0 that follows produces no `pkt_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLKS_PER_BIT` periods per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| line_dp | input | 1 | Sampled D+ level, already synchronous to `clk` |
| line_dm | input | 1 | Sampled D- level, already synchronous to `clk` |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Received byte, valid with `byte_vld` |
| byte_idx | output | $clog2(BUF_DEPTH+1) | Buffer slot for `byte_data` |
| pkt_end | output | 1 | One-cycle end-of-packet pulse |
| pkt_count | output | $clog2(BUF_DEPTH+1) | Whole bytes in the packet, valid with `pkt_end` |
| ovf_err | output | 1 | One-cycle buffer-overflow pulse |

## Verification
A wrong internal state shows up at the ports within one byte time. A sampler running on the wrong phase or a wrong NRZI reference corrupts the first `byte_data`. A stuffing counter that is off by one shifts every later bit, so all the following bytes are wrong. A bit-position error moves the SE0 decision, which shows as a wrong `pkt_count`, an extra or missing `pkt_end`, or a packet that ends at a byte boundary. A wrong fill count shows as `ovf_err` on the wrong byte or an index that skips.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;

  // Line codes as {D+, D-}
  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;
  localparam logic [1:0] LINE_SE0 = 2'b00;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYNC = 2'd1,
    ST_RECV = 2'd2
  } rx_state_e;

  function automatic logic is_j(input logic [1:0] ln);
    return ln == LINE_J;
  endfunction

  function automatic logic is_k(input logic [1:0] ln);
    return ln == LINE_K;
  endfunction

  function automatic logic is_se0(input logic [1:0] ln);
    return ln == LINE_SE0;
  endfunction

  // NRZI: an unchanged level is a one
  function automatic logic nrzi_bit(input logic lvl, input logic prev);
    return ~(lvl ^ prev);
  endfunction

endpackage

// File: rtl/lsrx_bit_timer.sv
module lsrx_bit_timer #(
  parameter int CLKS_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic strobe
);
  localparam int CW   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int HALF = CLKS_PER_BIT / 2;

  logic [CW-1:0] cnt_q;

  assign strobe = run && !restart && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= CW'(HALF - 1);
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? CW'(CLKS_PER_BIT - 1) : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lsrx_unstuff.sv
module lsrx_unstuff #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bit_en,
  input  logic lvl,
  output logic data_en,
  output logic data_bit
);
  localparam int OW = $clog2(STUFF_RUN + 1);

  logic          prev_q;
  logic [OW-1:0] ones_q;
  logic          stuffed;

  assign data_bit = lsrx_pkg::nrzi_bit(lvl, prev_q);
  assign stuffed  = (ones_q == OW'(STUFF_RUN));
  assign data_en  = bit_en && !stuffed;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_q <= 1'b0;   // last sync bit is K: D- low
      ones_q <= '0;
    end else if (bit_en) begin
      prev_q <= lvl;
      if (stuffed || !data_bit) ones_q <= '0;
      else                      ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/lsrx_assembler.sv
module lsrx_assembler #(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       shift_en,
  input  logic                       din,
  output logic [$clog2(BYTE_W)-1:0]  pos,
  output logic                       last_bit,
  output logic [BYTE_W-1:0]          byte_nxt
);
  localparam int PW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [PW-1:0]     pos_q;

  assign pos      = pos_q;
  assign last_bit = (pos_q == PW'(BYTE_W - 1));
  assign byte_nxt = {din, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sh_q  <= '0;
      pos_q <= '0;
    end else if (shift_en) begin
      sh_q  <= byte_nxt;
      pos_q <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/lowspeed_rx.sv
module lowspeed_rx #(
  parameter int CLKS_PER_BIT  = 10,
  parameter int BUF_DEPTH     = 11,
  parameter int SYNC_TMO_BITS = 4,
  parameter int STUFF_RUN     = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           line_dp,
  input  logic                           line_dm,
  output logic                           byte_vld,
  output logic [7:0]                     byte_data,
  output logic [$clog2(BUF_DEPTH+1)-1:0] byte_idx,
  output logic                           pkt_end,
  output logic [$clog2(BUF_DEPTH+1)-1:0] pkt_count,
  output logic                           ovf_err
);
  import lsrx_pkg::*;

  localparam int CW = $clog2(BUF_DEPTH + 1);
  localparam int TW = $clog2(SYNC_TMO_BITS + 1);
  localparam int PW = 3;

  rx_state_e     st_q;
  logic [1:0]    line_q;
  logic [1:0]    cur;
  logic          kseen_q;
  logic [TW-1:0] tmo_q;
  logic [CW-1:0] cnt_q;

  // named internal events
  logic          edge_jk, restart, run, bit_strobe;
  logic          in_recv, sync_strobe, recv_strobe;
  logic          sync_done, sync_abort;
  logic          end_evt, feed, data_en, data_bit;
  logic          last_bit, cnt_full, byte_evt, ovf_evt;
  logic [PW-1:0] bit_pos;
  logic [7:0]    byte_nxt;

  assign cur         = {line_dp, line_dm};
  assign edge_jk     = is_j(line_q) && is_k(cur);
  assign in_recv     = (st_q == ST_RECV);
  assign restart     = !in_recv && edge_jk;
  assign run         = (st_q != ST_HUNT);
  assign sync_strobe = bit_strobe && (st_q == ST_SYNC);
  assign recv_strobe = bit_strobe && in_recv;
  assign sync_done   = sync_strobe && is_k(cur) && kseen_q;
  assign sync_abort  = sync_strobe && !sync_done &&
                       (is_se0(cur) || tmo_q == TW'(SYNC_TMO_BITS - 1));
  assign end_evt     = recv_strobe && is_se0(cur) && (bit_pos != '0);
  assign feed        = recv_strobe && !end_evt;
  assign cnt_full    = (cnt_q == CW'(BUF_DEPTH));
  assign byte_evt    = data_en && last_bit && !cnt_full;
  assign ovf_evt     = data_en && last_bit && cnt_full;

  lsrx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (run),
    .strobe  (bit_strobe)
  );

  lsrx_unstuff #(.STUFF_RUN(STUFF_RUN)) u_unstuff (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sync_done),
    .bit_en   (feed),
    .lvl      (line_dm),
    .data_en  (data_en),
    .data_bit (data_bit)
  );

  lsrx_assembler #(.BYTE_W(8)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sync_done),
    .shift_en (data_en),
    .din      (data_bit),
    .pos      (bit_pos),
    .last_bit (last_bit),
    .byte_nxt (byte_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      line_q  <= LINE_J;
      kseen_q <= 1'b0;
      tmo_q   <= '0;
      cnt_q   <= '0;
    end else begin
      line_q <= cur;
      unique case (st_q)
        ST_HUNT: begin
          if (edge_jk) st_q <= ST_SYNC;
          kseen_q <= 1'b0;
          tmo_q   <= '0;
        end
        ST_SYNC: begin
          if (edge_jk) begin
            kseen_q <= 1'b0;
            tmo_q   <= '0;
          end else if (sync_done) begin
            st_q <= ST_RECV;
          end else if (sync_abort) begin
            st_q <= ST_HUNT;
          end else if (sync_strobe) begin
            kseen_q <= is_k(cur);
            tmo_q   <= tmo_q + 1'b1;
          end
        end
        ST_RECV: begin
          if (end_evt || ovf_evt) st_q <= ST_HUNT;
        end
        default: st_q <= ST_HUNT;
      endcase
      if (sync_done)     cnt_q <= '0;
      else if (byte_evt) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_idx  <= '0;
      pkt_end   <= 1'b0;
      pkt_count <= '0;
      ovf_err   <= 1'b0;
    end else begin
      byte_vld <= byte_evt;
      pkt_end  <= end_evt;
      ovf_err  <= ovf_evt;
      if (byte_evt) begin
        byte_data <= byte_nxt;
        byte_idx  <= cnt_q;
      end
      if (end_evt) pkt_count <= cnt_q;
    end
  end
endmodule

// File: rtl/lsrx_checker.sv
module lsrx_checker #(
  parameter int DEPTH = 11,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_vld,
  input logic [CW-1:0] byte_idx,
  input logic          pkt_end,
  input logic [CW-1:0] pkt_count,
  input logic          ovf_err,
  input logic          bit_strobe,
  input logic          in_recv,
  input logic          cnt_full,
  input logic [2:0]    bit_pos
);
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe); // R2

  AST_EVENT_FROM_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld || pkt_end || ovf_err) |-> $past(bit_strobe && in_recv)); // R4

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, pkt_end, ovf_err})); // R5

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (byte_idx < CW'(DEPTH))); // R5

  AST_END_LEAVES_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end || ovf_err) |-> !in_recv); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> (pkt_count <= CW'(DEPTH))); // R7

  AST_NO_END_AT_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> $past(bit_pos != 3'd0)); // R8

  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(cnt_full)); // R9
endmodule

bind lowspeed_rx lsrx_checker #(.DEPTH(BUF_DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_vld   (byte_vld),
  .byte_idx   (byte_idx),
  .pkt_end    (pkt_end),
  .pkt_count  (pkt_count),
  .ovf_err    (ovf_err),
  .bit_strobe (bit_strobe),
  .in_recv    (in_recv),
  .cnt_full   (cnt_full),
  .bit_pos    (bit_pos)
);

// File: tb/lowspeed_rx_tb.sv
module lowspeed_rx_tb;
  localparam int CPB   = 10;
  localparam int DEPTH = 11;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NVEC  = 7;

  localparam logic [1:0] SJ = 2'b01;
  localparam logic [1:0] SK = 2'b10;
  localparam logic [1:0] S0 = 2'b00;

  localparam int VEC_LEN [NVEC] = '{3, 1, 2, 4, 11, 12, 0};
  localparam logic [7:0] VEC_BYTES [NVEC][12] = '{
    '{8'hC3, 8'h2D, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h7E, 8'h3F, 8'hFC, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h76, 8'h87, 8'h98, 8'hA9, 8'hBA, 8'h00},
    '{8'hE1, 8'hD2, 8'hC3, 8'hB4, 8'hA5, 8'h96, 8'h87, 8'h78, 8'h69, 8'h5A, 8'h4B, 8'h3C},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0;
  logic dm = 1'b1;
  logic          byte_vld, pkt_end, ovf_err;
  logic [7:0]    byte_data;
  logic [CW-1:0] byte_idx, pkt_count;

  always #4 clk = ~clk;

  lowspeed_rx #(.CLKS_PER_BIT(CPB), .BUF_DEPTH(DEPTH)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_dp   (dp),
    .line_dm   (dm),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .byte_idx  (byte_idx),
    .pkt_end   (pkt_end),
    .pkt_count (pkt_count),
    .ovf_err   (ovf_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] cap_data[$];
  int         cap_idx[$];
  int         ends_seen = 0;
  int         last_count = -1;
  int         ovf_seen = 0;
  logic [1:0] syms[$];
  logic [7:0] pay [12];

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) begin
        cap_data.push_back(byte_data);
        cap_idx.push_back(int'(byte_idx));
      end
      if (pkt_end) begin
        ends_seen++;
        last_count = int'(pkt_count);
      end
      if (ovf_err) ovf_seen++;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic clear_capture();
    cap_data.delete();
    cap_idx.delete();
    ends_seen  = 0;
    last_count = -1;
    ovf_seen   = 0;
  endtask

  // idle, sync KJKJKJKK, NRZI data with stuffing, SE0 SE0, idle
  task automatic build(input int nbits, input int se0_at);
    logic lvl;
    int   ones;
    logic b;
    syms.delete();
    repeat (4) syms.push_back(SJ);
    for (int i = 0; i < 8; i++) syms.push_back((i % 2 == 0 || i == 7) ? SK : SJ);
    lvl  = 1'b0;
    ones = 0;
    for (int i = 0; i < nbits; i++) begin
      b = pay[i / 8][i % 8];
      if (!b) lvl = ~lvl;
      if (i == se0_at && !lvl) syms.push_back(S0);
      else                     syms.push_back(lvl ? SJ : SK);
      ones = b ? ones + 1 : 0;
      if (ones == 6) begin
        lvl = ~lvl;
        syms.push_back(lvl ? SJ : SK);
        ones = 0;
      end
    end
    syms.push_back(S0);
    syms.push_back(S0);
    repeat (8) syms.push_back(SJ);
  endtask

  task automatic send_all();
    foreach (syms[i]) begin
      {dp, dm} = syms[i];
      repeat (CPB) @(negedge clk);
    end
  endtask

  task automatic expect_pkt(input string tag, input int nbytes, input bit end_exp,
                            input int cnt_exp, input bit ovf_exp);
    check(cap_data.size() == nbytes, {tag, " R5 bytes delivered"}, cap_data.size(), nbytes);
    for (int i = 0; i < nbytes && i < cap_data.size(); i++) begin
      check(cap_data[i] == pay[i], {tag, " R4/R6 byte value"}, int'(cap_data[i]), int'(pay[i]));
      check(cap_idx[i] == i, {tag, " R5 byte index"}, cap_idx[i], i);
    end
    check(ends_seen == (end_exp ? 1 : 0), {tag, " R7 end pulses"}, ends_seen, end_exp ? 1 : 0);
    if (end_exp) check(last_count == cnt_exp, {tag, " R7 byte count"}, last_count, cnt_exp);
    check(ovf_seen == (ovf_exp ? 1 : 0), {tag, " R9 overflow pulses"}, ovf_seen, ovf_exp ? 1 : 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    check({byte_vld, pkt_end, ovf_err} == 3'b000, "R1 outputs in reset", int'({byte_vld, pkt_end, ovf_err}), 0);
    rst_n = 1'b1;
    clear_capture();
    repeat (40) @(negedge clk);
    check(cap_data.size() + ends_seen + ovf_seen == 0, "R1 idle after reset",
          cap_data.size() + ends_seen + ovf_seen, 0);

    // vector table: whole packets, stuffing, full buffer, overflow, empty
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < 12; i++) pay[i] = VEC_BYTES[v][i];
      clear_capture();
      build(VEC_LEN[v] * 8, -1);
      send_all();
      if (VEC_LEN[v] > DEPTH) expect_pkt("vector R9", DEPTH, 1'b0, 0, 1'b1);
      else                    expect_pkt("vector R4", VEC_LEN[v], 1'b1, VEC_LEN[v], 1'b0);
    end

    // R2: alternating sync without a K-K pair yields nothing
    clear_capture();
    syms.delete();
    repeat (4) syms.push_back(SJ);
    for (int i = 0; i < 6; i++) syms.push_back((i % 2 == 0) ? SK : SJ);
    repeat (8) syms.push_back(SJ);
    syms.push_back(S0);
    syms.push_back(S0);
    repeat (6) syms.push_back(SJ);
    send_all();
    check(cap_data.size() + ends_seen + ovf_seen == 0, "R2 no lock without double K",
          cap_data.size() + ends_seen + ovf_seen, 0);

    // R3: lone K edge, long J (sync timeout), then a good packet
    clear_capture();
    pay[0] = 8'h96; pay[1] = 8'h4E;
    build(16, -1);
    repeat (10) syms.push_front(SJ);
    syms.push_front(SK);
    repeat (4) syms.push_front(SJ);
    send_all();
    expect_pkt("R3 after timeout", 2, 1'b1, 2, 1'b0);

    // R7: SE0 in the middle of the third byte drops the partial byte
    clear_capture();
    pay[0] = 8'h3C; pay[1] = 8'hA7; pay[2] = 8'h00;
    build(19, -1);
    send_all();
    expect_pkt("R7 truncated", 2, 1'b1, 2, 1'b0);

    // R8: SE0 at bit 0 of the second byte read as a D- low level
    clear_capture();
    pay[0] = 8'h00; pay[1] = 8'hA5;
    build(16, 8);
    send_all();
    expect_pkt("R8 se0 at bit0", 2, 1'b1, 2, 1'b0);

    finish_run();
  end
endmodule